// File: doc/BRIEF.md
# Clock Gating Handshake Controller

This block is the controller side of automatic clock gating for one bus initiator and one bus target. It runs two independent handshake flows on an always-on clock and drives clock-enable outputs, which a separate clock gate cell consumes.

The initiator decides its own standby. When it reports standby, the controller removes its clock enables. When it asks to reactivate, the controller restores them. The target is asked instead of told. The controller raises an idle request only while an external "idle conditions met" input is high. It removes the target clock enable only after the target acknowledges. If no acknowledge comes, the clock stays on.

When a gated target sees a wake-up event, or the target itself asks to wake, the controller first turns the clock back on. It then waits a settle window of `WAKE_CLK_CYCLES` cycles, raises a wake-up request and holds it until the target acknowledges. A status output for each flow exposes the current state, so the order of enables and requests can be observed.

Top module: `cg_handshake_ctrl`

## Requirements
- R1: When the initiator flow is in its active state (status 0) and `init_standby` is sampled high with `init_wake` low, both `init_iclk_en` and `init_fclk_en` are 0 from the following cycle, and the initiator status reads 1 (standby).
- R2: When the initiator flow is in standby and `init_wake` is sampled high, `init_iclk_en` and `init_fclk_en` are both 1 from the following cycle, and the initiator status returns to 0.
- R3: `tgt_idle_req` rises only in the cycle after `tgt_idle_ok` was sampled high with the target status at 0 (active). The request then stays high through status 1 (requesting) and status 2 (gated).
- R4: While the target status is 1, `tgt_clk_en` stays 1 for as long as `tgt_idle_ack` stays low, however long that is. When `tgt_idle_ack` is sampled high, `tgt_clk_en` is 0 from the next cycle and the status reads 2.
- R5: When the target status is 1 and `tgt_idle_ok` is sampled low with no acknowledge, the controller withdraws the request. The next cycle shows `tgt_idle_req` at 0 and status 0.
- R6: When the target status is 2 and `tgt_wake_event` is sampled high, `tgt_clk_en` is 1 from the next cycle (status 3). `tgt_wake_req` rises exactly `WAKE_CLK_CYCLES` cycles later (status 4) and stays high until `tgt_wake_ack` is sampled high. The cycle after that, the status is 0 with `tgt_wake_req` at 0.
- R7: A target-originated wake (`tgt_wake_src` high while the status is 2) follows the same sequence as R6. `tgt_clk_en` is 1 the next cycle.
- R8: While `rst_n` is low at a clock edge, both flows return to status 0. All clock enables are then 1 and both requests are 0.
- R9: Status codes are as follows. Initiator: 0 means active, 1 means standby. Target: 0 means active, 1 means idle requested, 2 means gated, 3 means clock on before wake request, 4 means wake request. `tgt_wake_req` is high only in status 4, and `tgt_clk_en` is low only in status 2.
- R10: Inputs have no effect outside their own state. `tgt_idle_ack` is ignored in status 0. `tgt_wake_event` and `tgt_wake_src` are ignored outside status 2. `init_wake` is ignored while the initiator is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_standby | input | 1 | Initiator reports it has entered standby |
| init_wake | input | 1 | Initiator asks to reactivate |
| init_fclk_en | output | 1 | Initiator functional clock enable |
| init_iclk_en | output | 1 | Initiator interface clock enable |
| init_state | output | 1 | Initiator flow status |
| tgt_idle_ok | input | 1 | Target idle conditions are satisfied |
| tgt_idle_ack | input | 1 | Target acknowledges the idle request |
| tgt_wake_event | input | 1 | Wake-up event for the target |
| tgt_wake_src | input | 1 | Target itself asks for its clock |
| tgt_wake_ack | input | 1 | Target acknowledges the wake-up request |
| tgt_clk_en | output | 1 | Target clock enable |
| tgt_idle_req | output | 1 | Idle request toward the target |
| tgt_wake_req | output | 1 | Wake-up request toward the target |
| tgt_state | output | 3 | Target flow status |

## Verification
The hardest case to reach from the ports is the wake-up request. To get there, the target must first be asked for idle, acknowledge it while the idle conditions still hold, and be gated. A wake source must then fire, and the whole settle window must pass before the acknowledge can land. A directed sequence walks this path with exact cycle counts. A long random phase biases `tgt_idle_ok` high and the acknowledges toward moderate rates, so the path recurs with acknowledges that arrive early, late, or during the settle window. Every cycle is compared against a bench model.

// File: rtl/cg_pkg.sv
`timescale 1ns/1ps
// Package: shared state encodings for the clock gating handshake controller.
// Assumes: status codes are visible at the ports and must stay stable.
package cg_pkg;
    localparam int INIT_ST_W = 1;
    localparam int TGT_ST_W  = 3;

    typedef enum logic [INIT_ST_W-1:0] {
        I_ACTIVE  = 1'b0,
        I_STANDBY = 1'b1
    } init_st_e;

    typedef enum logic [TGT_ST_W-1:0] {
        T_ACTIVE   = 3'd0,
        T_IDLE_REQ = 3'd1,
        T_IDLE     = 3'd2,
        T_WAKE_CLK = 3'd3,
        T_WAKE_REQ = 3'd4
    } tgt_st_e;
endpackage

// File: rtl/cg_init_flow.sv
`timescale 1ns/1ps
// Module: cg_init_flow
// Initiator-side flow. It gates the initiator clocks when the initiator
// reports standby and restores them when the initiator asks to reactivate.
// Assumes: inputs are synchronous to clk; reset is synchronous, active low.
// GATE_FCLK selects whether the functional clock is gated in standby as well.
module cg_init_flow
    import cg_pkg::*;
#(
    parameter bit GATE_FCLK = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 standby_i,
    input  logic                 wake_i,
    output logic                 fclk_en_o,
    output logic                 iclk_en_o,
    output logic [INIT_ST_W-1:0] state_o
);
    init_st_e st, st_nx;

    // State register for the initiator flow.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= I_ACTIVE;
        else        st <= st_nx;
    end

    // Next-state decision from the initiator's own reports.
    always_comb begin
        st_nx = st;
        case (st)
            I_ACTIVE:  if (standby_i && !wake_i) st_nx = I_STANDBY;
            I_STANDBY: if (wake_i)               st_nx = I_ACTIVE;
            default:                             st_nx = I_ACTIVE;
        endcase
    end

    assign iclk_en_o = (st == I_ACTIVE);
    assign state_o   = st;

    generate
        if (GATE_FCLK) begin : g_fclk_gated
            assign fclk_en_o = (st == I_ACTIVE);
        end else begin : g_fclk_free
            assign fclk_en_o = 1'b1;
        end
    endgenerate

    assert_standby_gates_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == I_ACTIVE && standby_i && !wake_i) |=> !iclk_en_o);

    assert_wake_restores_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == I_STANDBY && wake_i) |=> (iclk_en_o && fclk_en_o));
endmodule

// File: rtl/cg_tgt_flow.sv
`timescale 1ns/1ps
// Module: cg_tgt_flow
// Target-side flow. It asks for idle when the idle conditions hold, gates the
// clock only after an acknowledge, and on a wake source turns the clock on,
// waits WAKE_CLK_CYCLES cycles, then raises a wake request until acknowledged.
// Assumes: inputs are synchronous to clk; reset is synchronous, active low.
module cg_tgt_flow
    import cg_pkg::*;
#(
    parameter int WAKE_CLK_CYCLES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                idle_ok_i,
    input  logic                idle_ack_i,
    input  logic                wake_event_i,
    input  logic                wake_src_i,
    input  logic                wake_ack_i,
    output logic                clk_en_o,
    output logic                idle_req_o,
    output logic                wake_req_o,
    output logic [TGT_ST_W-1:0] state_o
);
    localparam int CNT_W = (WAKE_CLK_CYCLES > 1) ? $clog2(WAKE_CLK_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAKE_CLK_CYCLES - 1);

    tgt_st_e          st, st_nx;
    logic [CNT_W-1:0] cnt;

    // State register for the target flow.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= T_ACTIVE;
        else        st <= st_nx;
    end

    // Settle counter: counts cycles spent with the clock on before the request.
    always_ff @(posedge clk) begin
        if (!rst_n)                                     cnt <= '0;
        else if (st == T_WAKE_CLK && st_nx == T_WAKE_CLK) cnt <= cnt + 1'b1;
        else                                            cnt <= '0;
    end

    // Next-state decision for the idle and wake handshakes.
    always_comb begin
        st_nx = st;
        case (st)
            T_ACTIVE:   if (idle_ok_i) st_nx = T_IDLE_REQ;
            T_IDLE_REQ: begin
                if (idle_ack_i)      st_nx = T_IDLE;
                else if (!idle_ok_i) st_nx = T_ACTIVE;
            end
            T_IDLE:     if (wake_event_i || wake_src_i) st_nx = T_WAKE_CLK;
            T_WAKE_CLK: if (cnt == CNT_LAST) st_nx = T_WAKE_REQ;
            T_WAKE_REQ: if (wake_ack_i)      st_nx = T_ACTIVE;
            default:                         st_nx = T_ACTIVE;
        endcase
    end

    assign clk_en_o   = (st != T_IDLE);
    assign idle_req_o = (st == T_IDLE_REQ) || (st == T_IDLE);
    assign wake_req_o = (st == T_WAKE_REQ);
    assign state_o    = st;

    assert_req_needs_ok_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle_req_o) |-> $past(idle_ok_i));

    assert_gate_needs_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_en_o) |-> $past(idle_ack_i));

    assert_withdraw_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == T_IDLE_REQ && !idle_ok_i && !idle_ack_i) |=> !idle_req_o);

    assert_clk_before_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_req_o) |-> ($past(clk_en_o) && clk_en_o));

    assert_wake_ungates_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == T_IDLE && (wake_event_i || wake_src_i)) |=> clk_en_o);

    assert_ack_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == T_ACTIVE && !idle_ok_i) |=> (clk_en_o && !idle_req_o));
endmodule

// File: rtl/cg_handshake_ctrl.sv
`timescale 1ns/1ps
// Module: cg_handshake_ctrl (top)
// Controller side of automatic clock gating for one initiator and one target.
// It drives clock enables, not gated clocks, and exposes the state of each flow.
// Assumes: one always-on clock; synchronous active-low reset.
module cg_handshake_ctrl
    import cg_pkg::*;
#(
    parameter bit GATE_INIT_FCLK  = 1'b1,
    parameter int WAKE_CLK_CYCLES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 init_standby,
    input  logic                 init_wake,
    output logic                 init_fclk_en,
    output logic                 init_iclk_en,
    output logic [INIT_ST_W-1:0] init_state,
    input  logic                 tgt_idle_ok,
    input  logic                 tgt_idle_ack,
    input  logic                 tgt_wake_event,
    input  logic                 tgt_wake_src,
    input  logic                 tgt_wake_ack,
    output logic                 tgt_clk_en,
    output logic                 tgt_idle_req,
    output logic                 tgt_wake_req,
    output logic [TGT_ST_W-1:0]  tgt_state
);
    cg_init_flow #(.GATE_FCLK(GATE_INIT_FCLK)) u_init (
        .clk       (clk),
        .rst_n     (rst_n),
        .standby_i (init_standby),
        .wake_i    (init_wake),
        .fclk_en_o (init_fclk_en),
        .iclk_en_o (init_iclk_en),
        .state_o   (init_state)
    );

    cg_tgt_flow #(.WAKE_CLK_CYCLES(WAKE_CLK_CYCLES)) u_tgt (
        .clk          (clk),
        .rst_n        (rst_n),
        .idle_ok_i    (tgt_idle_ok),
        .idle_ack_i   (tgt_idle_ack),
        .wake_event_i (tgt_wake_event),
        .wake_src_i   (tgt_wake_src),
        .wake_ack_i   (tgt_wake_ack),
        .clk_en_o     (tgt_clk_en),
        .idle_req_o   (tgt_idle_req),
        .wake_req_o   (tgt_wake_req),
        .state_o      (tgt_state)
    );
endmodule

// File: tb/tb_cg_handshake_ctrl.sv
`timescale 1ns/1ps
// Bench: tb_cg_handshake_ctrl
// Fixed-seed random stimulus plus directed corner cases. Every cycle is
// compared with a bench model written from the requirements.
module tb_cg_handshake_ctrl;
    localparam int WCC = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic init_standby = 1'b0, init_wake = 1'b0;
    logic tgt_idle_ok = 1'b0, tgt_idle_ack = 1'b0, tgt_wake_event = 1'b0;
    logic tgt_wake_src = 1'b0, tgt_wake_ack = 1'b0;
    logic init_fclk_en, init_iclk_en, tgt_clk_en, tgt_idle_req, tgt_wake_req;
    logic [0:0] init_state;
    logic [2:0] tgt_state;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench model state
    int m_ist = 0;
    int m_tst = 0;
    int m_cnt = 0;

    always #2.5 clk = ~clk;

    cg_handshake_ctrl #(.GATE_INIT_FCLK(1'b1), .WAKE_CLK_CYCLES(WCC)) dut (
        .clk(clk), .rst_n(rst_n),
        .init_standby(init_standby), .init_wake(init_wake),
        .init_fclk_en(init_fclk_en), .init_iclk_en(init_iclk_en),
        .init_state(init_state),
        .tgt_idle_ok(tgt_idle_ok), .tgt_idle_ack(tgt_idle_ack),
        .tgt_wake_event(tgt_wake_event), .tgt_wake_src(tgt_wake_src),
        .tgt_wake_ack(tgt_wake_ack),
        .tgt_clk_en(tgt_clk_en), .tgt_idle_req(tgt_idle_req),
        .tgt_wake_req(tgt_wake_req), .tgt_state(tgt_state)
    );

    function automatic int init_next(int s, logic sb, logic wk);
        if (s == 0) return (sb && !wk) ? 1 : 0;
        return wk ? 0 : 1;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Advance the model one edge using the inputs currently driven.
    task automatic model_step();
        int nt;
        int nc;
        m_ist = init_next(m_ist, init_standby, init_wake);
        nt = m_tst;
        nc = 0;
        case (m_tst)
            0: if (tgt_idle_ok) nt = 1;
            1: if (tgt_idle_ack) nt = 2; else if (!tgt_idle_ok) nt = 0;
            2: if (tgt_wake_event || tgt_wake_src) nt = 3;
            3: if (m_cnt == WCC - 1) nt = 4; else nc = m_cnt + 1;
            4: if (tgt_wake_ack) nt = 0;
            default: nt = 0;
        endcase
        m_tst = nt;
        m_cnt = nc;
    endtask

    task automatic compare_all();
        chk("R1", "init_iclk_en", int'(init_iclk_en), (m_ist == 0) ? 1 : 0);
        chk("R2", "init_fclk_en", int'(init_fclk_en), (m_ist == 0) ? 1 : 0);
        chk("R9", "init_state",   int'(init_state),   m_ist);
        chk("R3", "tgt_idle_req", int'(tgt_idle_req), (m_tst == 1 || m_tst == 2) ? 1 : 0);
        chk("R4", "tgt_clk_en",   int'(tgt_clk_en),   (m_tst != 2) ? 1 : 0);
        chk("R6", "tgt_wake_req", int'(tgt_wake_req), (m_tst == 4) ? 1 : 0);
        chk("R9", "tgt_state",    int'(tgt_state),    m_tst);
    endtask

    // Drive inputs (just after a falling edge), step the model, sample at next falling edge.
    task automatic cyc(logic sb, logic wk, logic ok, logic ack, logic ev, logic src, logic wack);
        init_standby = sb; init_wake = wk;
        tgt_idle_ok = ok; tgt_idle_ack = ack; tgt_wake_event = ev;
        tgt_wake_src = src; tgt_wake_ack = wack;
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL R8 watchdog: actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // Reset with all inputs quiet and then with inputs active (R8)
        repeat (3) @(negedge clk);
        tgt_idle_ok = 1'b1; init_standby = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8", "reset init_iclk_en", int'(init_iclk_en), 1);
        chk("R8", "reset init_fclk_en", int'(init_fclk_en), 1);
        chk("R8", "reset tgt_clk_en",   int'(tgt_clk_en), 1);
        chk("R8", "reset tgt_idle_req", int'(tgt_idle_req), 0);
        chk("R8", "reset tgt_wake_req", int'(tgt_wake_req), 0);
        chk("R8", "reset tgt_state",    int'(tgt_state), 0);
        chk("R8", "reset init_state",   int'(init_state), 0);
        init_standby = 1'b0; tgt_idle_ok = 1'b0;
        rst_n = 1'b1;

        // R10: idle ack, wake sources and init wake ignored when active
        cyc(0, 1, 0, 1, 1, 1, 1);
        chk("R10", "clk stays on", int'(tgt_clk_en), 1);
        chk("R10", "no idle req",  int'(tgt_idle_req), 0);
        chk("R10", "tgt status",   int'(tgt_state), 0);
        chk("R10", "init active",  int'(init_iclk_en), 1);

        // R3: idle request follows idle_ok
        cyc(0, 0, 1, 0, 0, 0, 0);
        chk("R3", "idle_req up", int'(tgt_idle_req), 1);
        // R4: no acknowledge keeps clock on indefinitely
        for (int i = 0; i < 40; i++) cyc(0, 0, 1, 0, 0, 0, 0);
        chk("R4", "clock held without ack", int'(tgt_clk_en), 1);
        // R5: idle conditions drop, request withdrawn
        cyc(0, 0, 0, 0, 0, 0, 0);
        chk("R5", "idle_req withdrawn", int'(tgt_idle_req), 0);
        chk("R5", "status active",      int'(tgt_state), 0);

        // R4: ack gates the clock
        cyc(0, 0, 1, 0, 0, 0, 0);
        cyc(0, 0, 1, 1, 0, 0, 0);
        chk("R4", "clock gated after ack", int'(tgt_clk_en), 0);
        chk("R4", "status gated", int'(tgt_state), 2);
        // R10: wake ack ignored while gated
        cyc(0, 0, 0, 0, 0, 0, 1);
        chk("R10", "still gated", int'(tgt_clk_en), 0);

        // R6: wake event: clock first, request WCC cycles later
        cyc(0, 0, 0, 0, 1, 0, 0);
        chk("R6", "clock on after event", int'(tgt_clk_en), 1);
        chk("R6", "no request yet",       int'(tgt_wake_req), 0);
        for (int i = 1; i < WCC; i++) begin
            cyc(0, 0, 0, 0, 0, 0, 0);
            chk("R6", "request held off in window", int'(tgt_wake_req), 0);
        end
        cyc(0, 0, 0, 0, 0, 0, 0);
        chk("R6", "request raised", int'(tgt_wake_req), 1);
        cyc(0, 0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0);
        chk("R6", "request held until ack", int'(tgt_wake_req), 1);
        cyc(0, 0, 0, 0, 0, 0, 1);
        chk("R6", "request cleared", int'(tgt_wake_req), 0);
        chk("R6", "status active",   int'(tgt_state), 0);

        // R7: target-originated wake
        cyc(0, 0, 1, 1, 0, 0, 0);
        cyc(0, 0, 0, 1, 0, 0, 0);
        chk("R7", "gated before src", int'(tgt_clk_en), 0);
        cyc(0, 0, 0, 0, 0, 1, 0);
        chk("R7", "clock on after src", int'(tgt_clk_en), 1);
        chk("R7", "status 3", int'(tgt_state), 3);
        for (int i = 0; i < WCC; i++) cyc(0, 0, 0, 0, 0, 0, 0);
        chk("R7", "request after src", int'(tgt_wake_req), 1);
        cyc(0, 0, 0, 0, 0, 0, 1);

        // R1/R2: initiator standby and reactivation
        cyc(1, 0, 0, 0, 0, 0, 0);
        chk("R1", "iclk gated", int'(init_iclk_en), 0);
        chk("R1", "fclk gated", int'(init_fclk_en), 0);
        cyc(1, 0, 0, 0, 0, 0, 0);
        chk("R1", "stays in standby", int'(init_state), 1);
        cyc(1, 1, 0, 0, 0, 0, 0);
        chk("R2", "iclk restored", int'(init_iclk_en), 1);
        chk("R2", "fclk restored", int'(init_fclk_en), 1);
        cyc(0, 0, 0, 0, 0, 0, 0);

        // Random phase, biased to reach the wake path often
        for (int i = 0; i < 4000; i++) begin
            cyc(($urandom % 100) < 30, ($urandom % 100) < 30,
                ($urandom % 100) < 80, ($urandom % 100) < 25,
                ($urandom % 100) < 15, ($urandom % 100) < 10,
                ($urandom % 100) < 30);
        end

        // Reset in mid-flight (R8)
        cyc(0, 0, 1, 1, 0, 0, 0);
        rst_n = 1'b0;
        m_ist = 0; m_tst = 0; m_cnt = 0;
        @(negedge clk);
        chk("R8", "mid reset tgt_state", int'(tgt_state), 0);
        chk("R8", "mid reset tgt_clk_en", int'(tgt_clk_en), 1);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule